// File: doc/BRIEF.md
# Capture Snapshot Queue with Overflow Lockout

This block holds up to four timer snapshots. Each one is taken when a capture strobe fires. Software reads them back through a read strobe. The oldest snapshot is always shown on the read-data output. A read removes it, and every remaining entry moves one slot closer to the output. A not-empty flag tells the reader that data is waiting. A sticky overflow flag reports that an event was lost.

A capture that arrives while all four slots are full is dropped and sets the overflow flag. From then on the queue refuses every capture until the reader has emptied it. This keeps the stored sequence consistent with what was seen before the loss. A mode input suppresses overflow signalling for the every-edge capture mode. In that mode a capture into a full queue is still dropped, but the flag is not raised and no lockout starts. The clear input drops the overflow flag.

Top module: `capt_fifo`

## Requirements
- R1: During and after reset the queue is empty: not_empty_o is 0 and ovf_o is 0.
- R2: rd_data_o always shows the oldest stored word. A read removes that word, so successive reads return the words in capture order.
- R3: not_empty_o goes to 1 in the cycle after the first capture is stored. It stays 1 until the read that removes the last stored word.
- R4: With no_ovf_i at 0, a capture into a full queue with no read in the same cycle is discarded, and ovf_o reads 1 in the next cycle.
- R5: After an overflow, captures are ignored until the stored count reaches zero. A capture given after the queue has drained is stored.
- R6: ovf_o is sticky. Draining the queue does not clear it. clr_i drops it to 0 in the next cycle. A new overflow in the same cycle as clr_i wins, and the flag stays 1.
- R7: With no_ovf_i at 1, a capture into a full queue is discarded, ovf_o is unchanged and no lockout starts. A capture that follows a read is stored.
- R8: A read of an empty queue changes no state. not_empty_o stays 0 and later captures read back correctly.
- R9: A read and a capture in the same cycle on a full queue that is not locked out are both performed, read first. The new word is stored and ovf_o is not set.
- R10: A read and a capture in the same cycle on an empty queue store the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_i | input | 1 | Capture strobe, one event per cycle |
| cap_data_i | input | 16 | Timer snapshot stored on a capture |
| rd_i | input | 1 | Read strobe: pops the oldest word |
| no_ovf_i | input | 1 | 1 = every-edge mode, overflow is never signalled |
| clr_i | input | 1 | Clears the overflow flag |
| rd_data_o | output | 16 | Oldest stored word |
| not_empty_o | output | 1 | At least one word is stored |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A read and a capture can land in the same cycle. How they combine depends on the fill level and the lockout state. The bench drives both strobes together on a full queue that is not locked out. It expects the capture to be stored and no overflow. It drives them together again on an empty queue, where the capture must be stored. It also drives them together on a locked-out queue, where the capture must be ignored. A second collision, overflow together with clr_i, is provoked on a full queue, and the bench expects the flag to stay set. Every read is judged against a scoreboard queue filled only with the captures the requirements say are stored.

// File: rtl/capt_fifo_pkg.sv
package capt_fifo_pkg;
  localparam int unsigned CF_DEPTH = 4;
  localparam int unsigned CF_WIDTH = 16;

  typedef struct packed {
    logic pop;
    logic push;
  } cf_op_t;
endpackage

// File: rtl/capt_fifo_store.sv
module capt_fifo_store #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pop_i,
  input  logic             push_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] head_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [WIDTH-1:0] shifted;
    if (i < DEPTH - 1) begin : g_mid
      assign shifted = pop_i ? slot_q[i+1] : slot_q[i];
    end else begin : g_last
      assign shifted = slot_q[i];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[i] <= '0;
      else if (push_i && wr_idx_i == IW'(i)) slot_q[i] <= wr_data_i;
      else slot_q[i] <= shifted;
    end
  end

  assign head_o = slot_q[0];
endmodule

// File: rtl/capt_fifo_ctrl.sv
module capt_fifo_ctrl
  import capt_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          rd_i,
  input  logic          no_ovf_i,
  input  logic          clr_i,
  output cf_op_t        op_o,
  output logic [CW-1:0] fill_mid_o,
  output logic [CW-1:0] cnt_o,
  output logic          lock_o,
  output logic          ovf_o
);
  logic [CW-1:0] cnt_q, cnt_d, cnt_mid;
  logic lock_q, lock_d, ovf_q, ovf_d;
  logic take, room, ovf_set;

  always_comb begin
    op_o.pop  = rd_i && (cnt_q != '0);
    cnt_mid   = op_o.pop ? cnt_q - CW'(1) : cnt_q;  // read applied first
    room      = cnt_mid != CW'(DEPTH);
    take      = cap_i && !lock_q;
    op_o.push = take && room;
    ovf_set   = take && !room && !no_ovf_i;
    cnt_d     = op_o.push ? cnt_mid + CW'(1) : cnt_mid;
    lock_d    = ovf_set ? 1'b1 : ((cnt_d == '0) ? 1'b0 : lock_q);
    ovf_d     = ovf_set ? 1'b1 : (clr_i ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
      ovf_q  <= ovf_d;
    end
  end

  assign fill_mid_o = cnt_mid;
  assign cnt_o      = cnt_q;
  assign lock_o     = lock_q;
  assign ovf_o      = ovf_q;
endmodule

// File: rtl/capt_fifo.sv
module capt_fifo
  import capt_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = CF_WIDTH,
  parameter int unsigned DEPTH = CF_DEPTH,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] cap_data_i,
  input  logic             rd_i,
  input  logic             no_ovf_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             not_empty_o,
  output logic             ovf_o
);
  cf_op_t        op;
  logic [CW-1:0] fill_mid, cnt;
  logic          lock;

  capt_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_i), .rd_i(rd_i),
    .no_ovf_i(no_ovf_i), .clr_i(clr_i), .op_o(op), .fill_mid_o(fill_mid),
    .cnt_o(cnt), .lock_o(lock), .ovf_o(ovf_o)
  );

  capt_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .pop_i(op.pop), .push_i(op.push),
    .wr_idx_i(fill_mid[IW-1:0]), .wr_data_i(cap_data_i), .head_o(rd_data_o)
  );

  assign not_empty_o = cnt != '0;
endmodule

// File: rtl/capt_fifo_chk.sv
module capt_fifo_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cap_i,
  input logic          rd_i,
  input logic          no_ovf_i,
  input logic          clr_i,
  input logic          not_empty_o,
  input logic          ovf_o,
  input logic [CW-1:0] cnt,
  input logic          lock
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!not_empty_o && !ovf_o && !lock));

  assert_hold_nonempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (not_empty_o && !rd_i) |=> not_empty_o);

  assert_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CW'(DEPTH) && cap_i && !rd_i && !no_ovf_i && !lock) |=> ovf_o);

  assert_lockout_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && cap_i && !rd_i) |=> (cnt == $past(cnt)));

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_ovf_i && cap_i && cnt == CW'(DEPTH) && !rd_i) |=> (ovf_o == $past(ovf_o)));

  assert_empty_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !cap_i && !not_empty_o) |=> !not_empty_o);

  assert_read_write_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CW'(DEPTH) && rd_i && cap_i && !lock && !clr_i)
      |=> (cnt == CW'(DEPTH) && ovf_o == $past(ovf_o)));

  assert_read_write_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_empty_o && rd_i && cap_i && !lock) |=> not_empty_o);
endmodule

bind capt_fifo capt_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_i), .rd_i(rd_i),
  .no_ovf_i(no_ovf_i), .clr_i(clr_i), .not_empty_o(not_empty_o),
  .ovf_o(ovf_o), .cnt(cnt), .lock(lock)
);

// File: tb/capt_fifo_bench.sv
module capt_fifo_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cap_i = 1'b0;
  logic [15:0] cap_data_i = '0;
  logic        rd_i = 1'b0;
  logic        no_ovf_i = 1'b0;
  logic        clr_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        not_empty_o, ovf_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] sb[$];
  bit m_lock = 0;
  bit m_ovf = 0;

  capt_fifo u_capt_fifo (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle, keeps the scoreboard, monitors results
  task automatic step(input bit cap, input logic [15:0] d, input bit rd,
                      input bit clr, input bit nov, input string tag);
    bit pop, take, room, set;
    cap_i = cap; cap_data_i = d; rd_i = rd; clr_i = clr; no_ovf_i = nov;
    #1;
    pop = rd && sb.size() > 0;
    if (pop) begin
      check(rd_data_o == sb[0], tag, "rd_data", rd_data_o, sb[0]);
      void'(sb.pop_front());
    end
    take = cap && !m_lock;
    room = sb.size() < 4;
    set  = take && !room && !nov;
    if (take && room) sb.push_back(d);
    if (set) m_ovf = 1;
    else if (clr) m_ovf = 0;
    if (set) m_lock = 1;
    else if (sb.size() == 0) m_lock = 0;
    @(posedge clk_i);
    @(negedge clk_i);
    cap_i = 0; rd_i = 0; clr_i = 0;
    check(not_empty_o == (sb.size() != 0), tag, "not_empty", not_empty_o, sb.size() != 0);
    check(ovf_o == m_ovf, tag, "ovf", ovf_o, m_ovf);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #20000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1;
    check(!not_empty_o && !ovf_o, "R1", "in reset", {not_empty_o, ovf_o}, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!not_empty_o && !ovf_o, "R1", "after reset", {not_empty_o, ovf_o}, 0);
    // R2 / R3: order and not-empty
    step(1, 16'h1111, 0, 0, 0, "R3");
    step(1, 16'h2222, 0, 0, 0, "R2");
    step(1, 16'h3333, 0, 0, 0, "R2");
    step(0, 0, 1, 0, 0, "R2");
    step(0, 0, 1, 0, 0, "R3");
    step(0, 0, 1, 0, 0, "R3");
    // R8: empty read
    step(0, 0, 1, 0, 0, "R8");
    step(1, 16'h0a0a, 0, 0, 0, "R8");
    step(0, 0, 1, 0, 0, "R8");
    // R10: read and capture on empty
    step(1, 16'hbeef, 1, 0, 0, "R10");
    // R9: fill, then read + capture on full
    for (int i = 0; i < 3; i++) step(1, 16'h4000 + 16'(i), 0, 0, 0, "R9");
    step(1, 16'hc0de, 1, 0, 0, "R9");
    // R4 / R5: overflow and lockout
    step(1, 16'hdead, 0, 0, 0, "R4");
    step(1, 16'hdea1, 0, 0, 0, "R5");
    step(0, 0, 1, 0, 0, "R5");
    step(1, 16'hdea2, 0, 0, 0, "R5");
    step(1, 16'hdea3, 1, 0, 0, "R5");
    step(0, 0, 1, 0, 0, "R5");
    step(1, 16'hdea4, 1, 0, 0, "R5");
    // R6: sticky after drain, then clear
    step(0, 0, 0, 0, 0, "R6");
    step(1, 16'h5151, 0, 0, 0, "R5");
    step(0, 0, 1, 0, 0, "R5");
    step(0, 0, 0, 1, 0, "R6");
    // R7: every-edge mode
    for (int i = 0; i < 4; i++) step(1, 16'h7000 + 16'(i), 0, 0, 1, "R7");
    step(1, 16'h7fff, 0, 0, 1, "R7");
    step(0, 0, 1, 0, 1, "R7");
    step(1, 16'h7abc, 0, 0, 1, "R7");
    // R6: overflow beats clear in the same cycle
    step(1, 16'h6666, 0, 1, 0, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, "R2");
    step(0, 0, 0, 1, 0, "R6");
    finish_run();
  end
endmodule